// File: doc/BRIEF.md
# Shared SMBus Port Router with Ownership Semaphore

This block stands between a single SMBus host engine and four physical bus ports. It decides which port the engine is connected to, and it arbitrates ownership of the engine between the host processor and an on-chip embedded controller. When neither side owns the engine, every port enable is low.

The host reaches a small configuration space through an address/data register pair. A write to the address register picks an internal register. Reads and writes of the data register then go to that register. A 2-bit port field sits in one of two configuration bytes, and a mode bit picks which one. A build-time layout parameter chooses a narrower variant in which the field lives in a different register and only two ports can be reached.

Ownership is a set-then-read-back semaphore held in a slave control byte. The host writes a request bit and reads the byte back to learn whether it was granted. It later writes a release bit. The embedded controller has its own request and release inputs. While the engine reports busy, the routed port is held, so that the port can be put back after a transfer without disturbing the transfer in progress.

Top module: `smbus_port_router`

## Requirements
- R1: After reset the following hold: the address register is 0, all configuration bytes are 0, there is no owner, `port_en` is 0 and `active_port` is 0.
- R2: A write with `acc_addr`=0 loads the address register, and a read with `acc_addr`=0 returns it. With `acc_addr`=1, reads and writes go to the register at the current address. Only addresses 0x02, 0x2C, 0x2E and 0x2F are backed by storage. Any other address reads 0, and writes to it are discarded.
- R3: In the default layout, when bit 0 of register 0x2F is 0, the port field is bits [2:1] of register 0x2C.
- R4: In the default layout, when bit 0 of register 0x2F is 1, the port field is bits [2:1] of register 0x2E.
- R5: In the alternate layout (`ALT_LAYOUT`=1), the port field is bits [4:3] of register 0x02. Only ports 0 and 1 can be reached: the field's upper bit is ignored.
- R6: A slave control write with bit 4 set, made while there is no owner and `ec_req` is low, grants the host. `sc_rdata` bit 4 reads 1 from the next cycle. A host request made while the embedded controller owns the engine is not granted.
- R7: A slave control write with bit 5 set, made while the host owns the engine, frees it on the next cycle. When bits 4 and 5 are written together on a free engine, nothing is granted.
- R8: When the engine is free, `ec_req` grants the embedded controller (`ec_grant`) on the next cycle, and it also wins a tie with a host request in the same cycle. `ec_rel` frees the engine. The host and the embedded controller never own the engine at the same time.
- R9: While either side owns the engine, `port_en` is one-hot on `active_port`. While the engine is free, `port_en` is 0.
- R10: `active_port` takes the selected field one cycle after the field changes, which is two cycles after the data write. While `eng_busy` is high it holds its value. It follows the field again on the cycle after `eng_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Configuration access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = address register, 1 = data register |
| acc_wdata | input | 8 | Configuration write data |
| acc_rdata | output | 8 | Configuration read data (combinational) |
| sc_we | input | 1 | Slave control write strobe |
| sc_wdata | input | 8 | Slave control write data: bit 4 requests, bit 5 releases |
| sc_rdata | output | 8 | Slave control read: bit 4 = host owns the engine |
| ec_req | input | 1 | Embedded controller ownership request |
| ec_rel | input | 1 | Embedded controller release |
| ec_grant | output | 1 | Embedded controller owns the engine |
| eng_busy | input | 1 | Engine transfer in progress |
| active_port | output | 2 | Port currently routed |
| port_en | output | 4 | One-hot port enable, all 0 when the engine is free |

## Verification
Ownership results, meaning `sc_rdata` bit 4, `ec_grant` and the resulting `port_en`, are due one clock edge after the request or release. The bench therefore samples them at the falling edge that follows the capturing edge. A port field change travels through two registers: the configuration byte first, then the routed port. Each configuration write is therefore followed by one idle cycle before `active_port` and `port_en` are compared with the model. Busy-hold checks sample several cycles into the busy window, and again one edge after busy falls.

// File: rtl/smbsel_pkg.sv
package smbsel_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_EC   = 2'd2
    } owner_e;

    localparam logic [7:0] IDX_ALTSEL = 8'h02;
    localparam logic [7:0] IDX_PRIM   = 8'h2C;
    localparam logic [7:0] IDX_SEC    = 8'h2E;
    localparam logic [7:0] IDX_MODE   = 8'h2F;

    localparam int SEL_LSB_STD = 1;
    localparam int SEL_LSB_ALT = 3;
    localparam int SC_REQ_BIT  = 4;
    localparam int SC_REL_BIT  = 5;
endpackage

// File: rtl/smbsel_cfg_regs.sv
module smbsel_cfg_regs
    import smbsel_pkg::*;
#(
    parameter int DW         = 8,
    parameter int PW         = 2,
    parameter int ALT_LAYOUT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_we,
    input  logic          acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    output logic [PW-1:0] sel_field
);
    typedef struct packed {
        logic [DW-1:0] idx;
        logic [DW-1:0] r_alt;
        logic [DW-1:0] r_prim;
        logic [DW-1:0] r_sec;
        logic [DW-1:0] r_mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (acc_en && acc_we) begin
            if (!acc_addr) begin
                cfg_d.idx = acc_wdata;
            end else begin
                case (cfg_q.idx)
                    IDX_ALTSEL: cfg_d.r_alt  = acc_wdata;
                    IDX_PRIM:   cfg_d.r_prim = acc_wdata;
                    IDX_SEC:    cfg_d.r_sec  = acc_wdata;
                    IDX_MODE:   cfg_d.r_mode = acc_wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        if (!acc_addr) begin
            acc_rdata = cfg_q.idx;
        end else begin
            case (cfg_q.idx)
                IDX_ALTSEL: acc_rdata = cfg_q.r_alt;
                IDX_PRIM:   acc_rdata = cfg_q.r_prim;
                IDX_SEC:    acc_rdata = cfg_q.r_sec;
                IDX_MODE:   acc_rdata = cfg_q.r_mode;
                default:    acc_rdata = '0;
            endcase
        end
    end

    generate
        if (ALT_LAYOUT != 0) begin : g_alt
            // narrow layout: only the two lowest ports are reachable
            assign sel_field = PW'(cfg_q.r_alt[SEL_LSB_ALT]);
        end else begin : g_std
            assign sel_field = cfg_q.r_mode[0] ? cfg_q.r_sec[SEL_LSB_STD +: PW]
                                               : cfg_q.r_prim[SEL_LSB_STD +: PW];
        end
    endgenerate
endmodule

// File: rtl/smbsel_sema.sv
module smbsel_sema
    import smbsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   host_req,
    input  logic   host_rel,
    input  logic   ec_req,
    input  logic   ec_rel,
    output owner_e owner
);
    owner_e own_d, own_q;

    always_comb begin
        own_d = own_q;
        case (own_q)
            OWN_NONE: begin
                if (ec_req)                    own_d = OWN_EC;
                else if (host_req && !host_rel) own_d = OWN_HOST;
            end
            OWN_HOST: if (host_rel) own_d = OWN_NONE;
            OWN_EC:   if (ec_rel)   own_d = OWN_NONE;
            default:  own_d = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= OWN_NONE;
        else        own_q <= own_d;
    end

    assign owner = own_q;
endmodule

// File: rtl/smbsel_route.sv
module smbsel_route
    import smbsel_pkg::*;
#(
    parameter int NPORT = 4,
    localparam int PW   = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    sel_field,
    input  logic             eng_busy,
    input  owner_e           owner,
    output logic [PW-1:0]    active_port,
    output logic [NPORT-1:0] port_en
);
    logic [PW-1:0] act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (!eng_busy) act_d = sel_field;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign active_port = act_q;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_en
            assign port_en[i] = (owner != OWN_NONE) && (act_q == PW'(i));
        end
    endgenerate
endmodule

// File: rtl/smbus_port_router.sv
module smbus_port_router
    import smbsel_pkg::*;
#(
    parameter int NPORT      = 4,
    parameter int DW         = 8,
    parameter int ALT_LAYOUT = 0,
    localparam int PW        = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic             acc_addr,
    input  logic [DW-1:0]    acc_wdata,
    output logic [DW-1:0]    acc_rdata,
    input  logic             sc_we,
    input  logic [DW-1:0]    sc_wdata,
    output logic [DW-1:0]    sc_rdata,
    input  logic             ec_req,
    input  logic             ec_rel,
    output logic             ec_grant,
    input  logic             eng_busy,
    output logic [PW-1:0]    active_port,
    output logic [NPORT-1:0] port_en
);
    logic [PW-1:0] sel_field;
    owner_e        owner;

    smbsel_cfg_regs #(.DW(DW), .PW(PW), .ALT_LAYOUT(ALT_LAYOUT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .sel_field (sel_field)
    );

    smbsel_sema u_sema (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_req (sc_we && sc_wdata[SC_REQ_BIT]),
        .host_rel (sc_we && sc_wdata[SC_REL_BIT]),
        .ec_req   (ec_req),
        .ec_rel   (ec_rel),
        .owner    (owner)
    );

    smbsel_route #(.NPORT(NPORT)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_field   (sel_field),
        .eng_busy    (eng_busy),
        .owner       (owner),
        .active_port (active_port),
        .port_en     (port_en)
    );

    always_comb begin
        sc_rdata = '0;
        sc_rdata[SC_REQ_BIT] = (owner == OWN_HOST);
    end

    assign ec_grant = (owner == OWN_EC);
endmodule

// File: rtl/smbus_port_router_chk.sv
module smbus_port_router_chk #(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    localparam int PW   = $clog2(NPORT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sc_we,
    input logic [DW-1:0]    sc_wdata,
    input logic [DW-1:0]    sc_rdata,
    input logic             ec_req,
    input logic             ec_rel,
    input logic             ec_grant,
    input logic             eng_busy,
    input logic [PW-1:0]    active_port,
    input logic [NPORT-1:0] port_en
);
    logic host_own;
    assign host_own = sc_rdata[4];

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_own && ec_grant));

    assert_ec_tie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_req && !ec_grant && !host_own) |=> ec_grant);

    assert_host_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_own && sc_we && sc_wdata[5]) |=> !host_own);

    assert_free_no_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_own && !ec_grant) |-> (port_en == '0));

    assert_owned_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_own || ec_grant) |-> ($countones(port_en) == 1));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable(active_port));
endmodule

bind smbus_port_router smbus_port_router_chk #(.NPORT(NPORT), .DW(DW)) u_chk (.*);

// File: tb/tb_smbus_port_router.sv
module tb_smbus_port_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, acc_we = 1'b0, acc_addr = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata, acc_rdata_alt;
    logic       sc_we = 1'b0;
    logic [7:0] sc_wdata = '0;
    logic [7:0] sc_rdata, sc_rdata_alt;
    logic       ec_req = 1'b0, ec_rel = 1'b0, eng_busy = 1'b0;
    logic       ec_grant, ec_grant_alt;
    logic [1:0] active_port, active_port_alt;
    logic [3:0] port_en, port_en_alt;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_prim = 0, m_sec = 0, m_mode = 0, m_alt = 0;
    int m_own = 0; // 0 none, 1 host, 2 ec

    always #2 clk = ~clk;

    smbus_port_router dut (
        .clk, .rst_n, .acc_en, .acc_we, .acc_addr, .acc_wdata, .acc_rdata,
        .sc_we, .sc_wdata, .sc_rdata, .ec_req, .ec_rel, .ec_grant,
        .eng_busy, .active_port, .port_en
    );

    smbus_port_router #(.ALT_LAYOUT(1)) dut_alt (
        .clk, .rst_n, .acc_en, .acc_we, .acc_addr, .acc_wdata,
        .acc_rdata(acc_rdata_alt), .sc_we, .sc_wdata, .sc_rdata(sc_rdata_alt),
        .ec_req, .ec_rel, .ec_grant(ec_grant_alt), .eng_busy,
        .active_port(active_port_alt), .port_en(port_en_alt)
    );

    function automatic logic [1:0] exp_port(input logic [7:0] p, s, m);
        return m[0] ? s[2:1] : p[2:1];
    endfunction

    function automatic logic [1:0] exp_alt(input logic [7:0] a);
        return {1'b0, a[3]};
    endfunction

    function automatic logic [3:0] exp_en(input int own, input logic [1:0] prt);
        return (own != 0) ? (4'b0001 << prt) : 4'b0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acc_write(input logic a, input logic [7:0] d);
        acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
        tick();
        acc_en = 0; acc_we = 0;
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        acc_write(1'b0, idx);
        acc_write(1'b1, d);
        case (idx)
            8'h02: m_alt = d;
            8'h2C: m_prim = d;
            8'h2E: m_sec = d;
            8'h2F: m_mode = d;
            default: ;
        endcase
    endtask

    task automatic cfg_read(input logic [7:0] idx, output logic [7:0] d);
        acc_write(1'b0, idx);
        acc_addr = 1'b1;
        #1 d = acc_rdata;
    endtask

    task automatic sc_write(input logic [7:0] d);
        sc_we = 1; sc_wdata = d;
        tick();
        sc_we = 0; sc_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd1234));
        repeat (3) tick();
        // R1 reset state
        chk("R1 port_en", port_en, 4'b0);
        chk("R1 active_port", active_port, 2'd0);
        chk("R1 owner", {sc_rdata, ec_grant}, 9'b0);
        rst_n = 1'b1;
        tick();
        acc_addr = 1'b0; #1 chk("R1 index reads 0", acc_rdata, 8'h00);
        cfg_read(8'h2C, rd); chk("R1 cfg 0x2C reset", rd, 8'h00);

        // R2 index/data path
        cfg_write(8'h2E, 8'hA5);
        cfg_read(8'h2E, rd); chk("R2 data readback", rd, 8'hA5);
        acc_addr = 1'b0; #1 chk("R2 index readback", acc_rdata, 8'h2E);
        cfg_write(8'h40, 8'hFF);
        cfg_read(8'h40, rd); chk("R2 unmapped reads 0", rd, 8'h00);
        cfg_read(8'h2E, rd); chk("R2 unmapped write discarded", rd, 8'hA5);
        cfg_write(8'h2E, 8'h00);

        // R6 host grant
        sc_write(8'h10);
        m_own = 1;
        chk("R6 host grant readback", sc_rdata[4], 1'b1);
        chk("R9 port0 when owned", port_en, 4'b0001);

        // R3 / R4 directed
        cfg_write(8'h2C, 8'h04); tick();
        chk("R3 prim field", active_port, 2'd2);
        chk("R9 onehot", port_en, 4'b0100);
        cfg_write(8'h2E, 8'h06); cfg_write(8'h2F, 8'h01); tick();
        chk("R4 sec field", active_port, 2'd3);

        // R10 latency: one idle cycle after the data write
        cfg_write(8'h2E, 8'h02);
        chk("R10 not yet updated", active_port, 2'd3);
        tick();
        chk("R10 updated", active_port, 2'd1);

        // R10 busy hold
        eng_busy = 1'b1;
        cfg_write(8'h2E, 8'h06);
        repeat (3) tick();
        chk("R10 busy hold", active_port, 2'd1);
        eng_busy = 1'b0;
        tick();
        chk("R10 follows after busy", active_port, 2'd3);

        // R3 random field sweep with mode changes
        for (int i = 0; i < 40; i++) begin
            logic [1:0] which = 2'($urandom_range(0, 2));
            logic [7:0] d = 8'($urandom);
            cfg_write(which == 0 ? 8'h2C : which == 1 ? 8'h2E : 8'h2F, d);
            tick();
            chk("R3/R4 random port", active_port, exp_port(m_prim, m_sec, m_mode));
            chk("R9 random enable", port_en, exp_en(m_own, exp_port(m_prim, m_sec, m_mode)));
        end

        // R5 alternate layout
        cfg_write(8'h02, 8'h18); tick();
        chk("R5 alt upper bit ignored", active_port_alt, 2'd1);
        cfg_write(8'h02, 8'h10); tick();
        chk("R5 alt field 2 maps to 0", active_port_alt, exp_alt(m_alt));

        // R8 ec blocked while host owns
        ec_req = 1'b1; tick(); ec_req = 1'b0;
        chk("R8 ec blocked by host", ec_grant, 1'b0);
        // R7 release
        sc_write(8'h20); m_own = 0;
        chk("R7 release", sc_rdata[4], 1'b0);
        chk("R9 free no port", port_en, 4'b0);
        // R7 both bits on free engine
        sc_write(8'h30);
        chk("R7 req+rel no grant", sc_rdata[4], 1'b0);
        // R8 tie
        ec_req = 1'b1; sc_we = 1'b1; sc_wdata = 8'h10;
        tick();
        ec_req = 1'b0; sc_we = 1'b0; sc_wdata = 8'h00;
        chk("R8 tie ec wins", ec_grant, 1'b1);
        chk("R8 tie host lost", sc_rdata[4], 1'b0);
        sc_write(8'h10);
        chk("R6 host blocked by ec", sc_rdata[4], 1'b0);
        ec_rel = 1'b1; tick(); ec_rel = 1'b0;
        chk("R8 ec release", ec_grant, 1'b0);

        // R6/R7/R8 random arbitration against a model
        m_own = 0;
        for (int i = 0; i < 200; i++) begin
            logic [3:0] r = 4'($urandom);
            logic hr = r[0], hl = r[1] & r[2], er = r[3], el = r[1] & ~r[2];
            sc_we = hr | hl; sc_wdata = {2'b0, hl, hr, 4'b0};
            ec_req = er; ec_rel = el;
            tick();
            case (m_own)
                0: if (er) m_own = 2; else if (hr && !hl) m_own = 1;
                1: if (hl) m_own = 0;
                default: if (el) m_own = 0;
            endcase
            chk("R6/R7 random host", sc_rdata[4], m_own == 1);
            chk("R8 random ec", ec_grant, m_own == 2);
            chk("R9 random en", port_en, exp_en(m_own, exp_port(m_prim, m_sec, m_mode)));
        end
        sc_we = 0; ec_req = 0; ec_rel = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule